// File: doc/BRIEF.md
# Byte ALU with Latched Condition Flags

This block is an 8-bit, three-operand integer unit that works over a small register file. One instruction per clock names a destination, a first source and either a second source register (register form) or an 8-bit immediate (immediate form), plus a 6-bit operation code. The result appears combinationally on `alu_result` and is written into the destination register at the next rising clock edge when the instruction is enabled. Register 0 is a hard zero.

Alongside the result the block derives nine condition bits from the two operands, the result and two status inputs from a neighbouring floating-point unit. These bits go into a flag register only when the instruction carries its save bit, so a program can compute a comparison on one line and keep the flags stable across later lines until it branches. A read-only peek port lets a neighbour read any register without issuing an instruction.

Top module: `byte_alu_top`

## Requirements
- R1: Register 0 always reads as 0 on every read port, and any write addressed to it is discarded.
- R2: While `rst_n` is low, all registers and all flag bits read 0; reset is applied asynchronously and released after two rising clock edges.
- R3: Arithmetic codes: 1 gives a+b, 2 gives a+b+1, 3 gives a-b, 4 gives a-b-1, all modulo 256, where a is the first source and b the second source register.
- R4: Bitwise and shift codes: 5 OR, 6 AND, 7 XOR, 8 NOT a, 9 logical right shift of a by one with 0 filled in at bit 7, 10 left shift of a by one with 0 filled in at bit 0.
- R5: Immediate codes: 11 gives a+imm and 12 gives a AND imm; the second source register is then ignored.
- R6: When `exec_en` is high and the code is 1 to 12, `alu_result` is written to the destination register at the rising edge; for any other code, or with `exec_en` low, no register changes and for other codes `alu_result` is 0.
- R7: Flag bit positions: 0 equal, 1 negative, 2 carry, 3 unsigned less, 4 unsigned greater, 5 signed less, 6 signed greater, 7 FPU zero, 8 FPU negative. Bits 0 and 3 to 6 compare the first operand with the second operand, which is the immediate for codes 11 and 12.
- R8: Negative is bit 7 of the result. Carry is the carry out of bit 7 for codes 1, 2 and 11; the absence of a borrow for codes 3 and 4; the bit shifted out for codes 9 and 10; 0 otherwise.
- R9: Flag bits 7 and 8 take the values of `fpu_zero` and `fpu_neg` at the saving edge.
- R10: All nine flags are written together at a rising edge where `exec_en` and `save_flags` are both high, and hold their value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Instruction valid this cycle |
| opcode | input | 6 | Operation code |
| dst_sel | input | 3 | Destination register |
| op1_sel | input | 3 | First source register |
| op2_sel | input | 3 | Second source register |
| imm | input | 8 | Immediate operand for codes 11 and 12 |
| save_flags | input | 1 | Latch the flags for this instruction |
| fpu_zero | input | 1 | FPU result-is-zero status |
| fpu_neg | input | 1 | FPU result-is-negative status |
| peek_sel | input | 3 | Register selected for the peek port |
| peek_data | output | 8 | Content of the peeked register |
| alu_result | output | 8 | Combinational result of the current instruction |
| flags | output | 9 | Flag register |

## Verification
A corrupted register entry stays hidden until it is read: it shows on `peek_data` as soon as that register is selected, or on `alu_result` in the same cycle an instruction sources it. A wrong flag computation or a missed save shows on `flags` exactly one edge after the saving instruction, while a spurious capture shows one edge after an instruction without the save bit. The bench therefore reads every destination back through the peek port and compares the flags right after each saving edge and after non-saving ones.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [5:0] {
    OP_NOP  = 6'd0,
    OP_ADD  = 6'd1,
    OP_ADDC = 6'd2,
    OP_SUB  = 6'd3,
    OP_SUBB = 6'd4,
    OP_OR   = 6'd5,
    OP_AND  = 6'd6,
    OP_XOR  = 6'd7,
    OP_NOT  = 6'd8,
    OP_SHR  = 6'd9,
    OP_SHL  = 6'd10,
    OP_ADDI = 6'd11,
    OP_ANDI = 6'd12
  } alu_op_e;

  localparam int unsigned FLAG_W   = 9;
  localparam int unsigned FL_EQ    = 0;
  localparam int unsigned FL_NEG   = 1;
  localparam int unsigned FL_CRY   = 2;
  localparam int unsigned FL_LTU   = 3;
  localparam int unsigned FL_GTU   = 4;
  localparam int unsigned FL_LTS   = 5;
  localparam int unsigned FL_GTS   = 6;
  localparam int unsigned FL_FZERO = 7;
  localparam int unsigned FL_FNEG  = 8;

endpackage

// File: rtl/byte_alu_regfile.sv
module byte_alu_regfile #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     ra_addr,
  input  logic [AW-1:0]     rb_addr,
  input  logic [AW-1:0]     rp_addr,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  output logic [DATA_W-1:0] rp_data
);

  logic [DATA_W-1:0] word [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    if (i == 0) begin : g_zero
      assign word[i] = '0;
    end else begin : g_store
      logic              hit;
      logic [DATA_W-1:0] q;
      always_comb hit = wr_en && (wr_addr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (hit) begin
          q <= wr_data;
        end
      end
      assign word[i] = q;
    end
  end

  always_comb begin
    ra_data = word[ra_addr];
    rb_data = word[rb_addr];
    rp_data = word[rp_addr];
  end

  // R6: a write to a non-zero entry is visible on the next cycle
  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0) |=> (word[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/byte_alu_compare.sv
module byte_alu_compare #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              eq,
  output logic              lt_u,
  output logic              gt_u,
  output logic              lt_s,
  output logic              gt_s
);

  always_comb begin
    eq   = (lhs == rhs);
    lt_u = (lhs < rhs);
    gt_u = (lhs > rhs);
    lt_s = ($signed(lhs) < $signed(rhs));
    gt_s = ($signed(lhs) > $signed(rhs));
  end

  // R7: exactly one of equal / less / greater in each ordering
  assert_unsigned_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({eq, lt_u, gt_u}));
  assert_signed_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({eq, lt_s, gt_s}));

endmodule

// File: rtl/byte_alu_exec.sv
module byte_alu_exec
  import byte_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [5:0]        op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] operand_b,
  output logic [DATA_W-1:0] result,
  output logic              carry,
  output logic              writes
);

  logic              use_imm;
  logic              invert_b;
  logic              cin;
  logic [DATA_W-1:0] adder_b;
  logic [DATA_W:0]   sum;

  always_comb begin
    use_imm   = (op == OP_ADDI) || (op == OP_ANDI);
    operand_b = use_imm ? imm : src_b;
    invert_b  = (op == OP_SUB) || (op == OP_SUBB);
    cin       = (op == OP_ADDC) || (op == OP_SUB);
    adder_b   = invert_b ? ~operand_b : operand_b;
    sum       = {1'b0, src_a} + {1'b0, adder_b} + (DATA_W+1)'(cin);
  end

  always_comb begin
    result = '0;
    carry  = 1'b0;
    writes = 1'b1;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_ADDI: begin
        result = sum[DATA_W-1:0];
        carry  = sum[DATA_W];
      end
      OP_OR:   result = src_a | operand_b;
      OP_AND,
      OP_ANDI: result = src_a & operand_b;
      OP_XOR:  result = src_a ^ operand_b;
      OP_NOT:  result = ~src_a;
      OP_SHR: begin
        result = {1'b0, src_a[DATA_W-1:1]};
        carry  = src_a[0];
      end
      OP_SHL: begin
        result = {src_a[DATA_W-2:0], 1'b0};
        carry  = src_a[DATA_W-1];
      end
      default: writes = 1'b0;
    endcase
  end

endmodule

// File: rtl/byte_alu_flagreg.sv
module byte_alu_flagreg
  import byte_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_en,
  input  logic [FLAG_W-1:0] flags_d,
  output logic [FLAG_W-1:0] flags_q
);

  logic [FLAG_W-1:0] flags_nxt;

  always_comb flags_nxt = save_en ? flags_d : flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_nxt;
    end
  end

  // R10: capture on save, hold otherwise
  assert_flag_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    save_en |=> (flags_q == $past(flags_d)));
  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !save_en |=> $stable(flags_q));

endmodule

// File: rtl/byte_alu_top.sv
module byte_alu_top
  import byte_alu_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [5:0]        opcode,
  input  logic [AW-1:0]     dst_sel,
  input  logic [AW-1:0]     op1_sel,
  input  logic [AW-1:0]     op2_sel,
  input  logic [DATA_W-1:0] imm,
  input  logic              save_flags,
  input  logic              fpu_zero,
  input  logic              fpu_neg,
  input  logic [AW-1:0]     peek_sel,
  output logic [DATA_W-1:0] peek_data,
  output logic [DATA_W-1:0] alu_result,
  output logic [FLAG_W-1:0] flags
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  logic [DATA_W-1:0] src_a, src_b, opnd_b, res;
  logic              cry, op_writes, rf_we;
  logic              eq, lt_u, gt_u, lt_s, gt_s;
  logic [FLAG_W-1:0] flags_d;

  byte_alu_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(rf_we), .wr_addr(dst_sel), .wr_data(res),
    .ra_addr(op1_sel), .rb_addr(op2_sel), .rp_addr(peek_sel),
    .ra_data(src_a), .rb_data(src_b), .rp_data(peek_data)
  );

  byte_alu_exec #(.DATA_W(DATA_W)) u_exec (
    .op(opcode), .src_a(src_a), .src_b(src_b), .imm(imm),
    .operand_b(opnd_b), .result(res), .carry(cry), .writes(op_writes)
  );

  byte_alu_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_int_n), .lhs(src_a), .rhs(opnd_b),
    .eq(eq), .lt_u(lt_u), .gt_u(gt_u), .lt_s(lt_s), .gt_s(gt_s)
  );

  always_comb begin
    rf_we            = exec_en && op_writes;
    flags_d          = '0;
    flags_d[FL_EQ]   = eq;
    flags_d[FL_NEG]  = res[DATA_W-1];
    flags_d[FL_CRY]  = cry;
    flags_d[FL_LTU]  = lt_u;
    flags_d[FL_GTU]  = gt_u;
    flags_d[FL_LTS]  = lt_s;
    flags_d[FL_GTS]  = gt_s;
    flags_d[FL_FZERO] = fpu_zero;
    flags_d[FL_FNEG] = fpu_neg;
  end

  byte_alu_flagreg u_flg (
    .clk(clk), .rst_n(rst_int_n), .save_en(exec_en && save_flags),
    .flags_d(flags_d), .flags_q(flags)
  );

  assign alu_result = res;

endmodule

// File: tb/byte_alu_top_tb.sv
module byte_alu_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_en = 1'b0;
  logic [5:0] opcode = '0;
  logic [2:0] dst_sel = '0, op1_sel = '0, op2_sel = '0, peek_sel = '0;
  logic [7:0] imm = '0;
  logic       save_flags = 1'b0, fpu_zero = 1'b0, fpu_neg = 1'b0;
  logic [7:0] peek_data, alu_result;
  logic [8:0] flags;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  byte_alu_top u_dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
    .dst_sel(dst_sel), .op1_sel(op1_sel), .op2_sel(op2_sel), .imm(imm),
    .save_flags(save_flags), .fpu_zero(fpu_zero), .fpu_neg(fpu_neg),
    .peek_sel(peek_sel), .peek_data(peek_data), .alu_result(alu_result),
    .flags(flags)
  );

  // {opcode, a, b, expected result}
  localparam logic [29:0] VEC [12] = '{
    {6'd1,  8'd200, 8'd100, 8'd44},
    {6'd2,  8'd10,  8'd20,  8'd31},
    {6'd3,  8'd5,   8'd9,   8'd252},
    {6'd4,  8'd9,   8'd5,   8'd3},
    {6'd5,  8'hA5,  8'h0F,  8'hAF},
    {6'd6,  8'hA5,  8'h0F,  8'h05},
    {6'd7,  8'hA5,  8'h0F,  8'hAA},
    {6'd8,  8'h3C,  8'h11,  8'hC3},
    {6'd9,  8'h81,  8'h22,  8'h40},
    {6'd10, 8'h81,  8'h81,  8'h02},
    {6'd1,  8'd255, 8'd1,   8'd0},
    {6'd3,  8'h80,  8'h01,  8'h7F}
  };

  function automatic logic [8:0] exp_flags(input logic [5:0] op, input logic [7:0] a,
      input logic [7:0] b, input logic [7:0] r, input logic fz, input logic fn);
    logic c;
    case (op)
      6'd1, 6'd11: c = (int'(a) + int'(b)) > 255;
      6'd2:        c = (int'(a) + int'(b) + 1) > 255;
      6'd3:        c = a >= b;
      6'd4:        c = a > b;
      6'd9:        c = a[0];
      6'd10:       c = a[7];
      default:     c = 1'b0;
    endcase
    return {fn, fz, $signed(a) > $signed(b), $signed(a) < $signed(b),
            a > b, a < b, c, r[7], a == b};
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act,
      input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic setup(input logic [5:0] op, input logic [2:0] d, input logic [2:0] s1,
      input logic [2:0] s2, input logic [7:0] im, input logic sv, input logic en);
    opcode = op; dst_sel = d; op1_sel = s1; op2_sel = s2; imm = im;
    save_flags = sv; exec_en = en;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    exec_en = 1'b0;
    save_flags = 1'b0;
  endtask

  task automatic peek(input logic [2:0] r, output logic [7:0] v);
    peek_sel = r;
    #1;
    v = peek_data;
  endtask

  task automatic load(input logic [2:0] r, input logic [7:0] v);
    setup(6'd11, r, 3'd0, 3'd0, v, 1'b0, 1'b1);
    tick();
  endtask

  initial begin
    #150000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [8:0] f_before;
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2", "flags after reset", 16'(flags), 16'h0);
    for (int r = 0; r < 8; r++) begin
      peek(3'(r), v);
      check("R2", "register after reset", 16'(v), 16'h0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R4 R7 R8 R9: vector table
    for (int i = 0; i < 12; i++) begin
      logic [5:0] op;
      logic [7:0] a, b, r;
      {op, a, b, r} = VEC[i];
      load(3'd1, a);
      load(3'd2, b);
      fpu_zero = i[0];
      fpu_neg  = i[1];
      setup(op, 3'd3, 3'd1, 3'd2, 8'h5A, 1'b1, 1'b1);
      #1;
      check("R3/R4", "combinational result", 16'(alu_result), 16'(r));
      tick();
      peek(3'd3, v);
      check("R6", "destination written", 16'(v), 16'(r));
      check("R7/R8/R9", "saved flags", 16'(flags),
            16'(exp_flags(op, a, b, r, i[0], i[1])));
    end

    // R5 R7: immediate forms use imm as second operand; R2 holds 0x01 here
    load(3'd1, 8'h7F);
    fpu_zero = 1'b1; fpu_neg = 1'b0;
    setup(6'd11, 3'd3, 3'd1, 3'd2, 8'h81, 1'b1, 1'b1);
    tick();
    peek(3'd3, v);
    check("R5", "ADDI result", 16'(v), 16'h00);
    check("R7", "ADDI flags against immediate", 16'(flags),
          16'(exp_flags(6'd11, 8'h7F, 8'h81, 8'h00, 1'b1, 1'b0)));
    setup(6'd12, 3'd4, 3'd1, 3'd2, 8'hF0, 1'b1, 1'b1);
    tick();
    peek(3'd4, v);
    check("R5", "ANDI result", 16'(v), 16'h70);
    check("R7", "ANDI flags against immediate", 16'(flags),
          16'(exp_flags(6'd12, 8'h7F, 8'hF0, 8'h70, 1'b1, 1'b0)));

    // R1: write to register 0 discarded, reads zero
    setup(6'd11, 3'd0, 3'd0, 3'd0, 8'h55, 1'b0, 1'b1);
    tick();
    peek(3'd0, v);
    check("R1", "register 0 after write", 16'(v), 16'h0);
    setup(6'd1, 3'd5, 3'd0, 3'd0, 8'h00, 1'b0, 1'b1);
    #1;
    check("R1", "R0+R0 result", 16'(alu_result), 16'h0);
    tick();

    // R6: exec_en low writes nothing
    load(3'd5, 8'h33);
    setup(6'd11, 3'd5, 3'd0, 3'd0, 8'h99, 1'b1, 1'b0);
    tick();
    peek(3'd5, v);
    check("R6", "no write with exec_en low", 16'(v), 16'h33);

    // R6: non-ALU code (13) writes nothing and yields 0
    load(3'd6, 8'h44);
    setup(6'd13, 3'd6, 3'd1, 3'd2, 8'h00, 1'b0, 1'b1);
    #1;
    check("R6", "result for code 13", 16'(alu_result), 16'h0);
    tick();
    peek(3'd6, v);
    check("R6", "no write for code 13", 16'(v), 16'h44);
    setup(6'd0, 3'd6, 3'd1, 3'd2, 8'h00, 1'b0, 1'b1);
    tick();
    peek(3'd6, v);
    check("R6", "no write for code 0", 16'(v), 16'h44);

    // R10: flags hold without save bit
    f_before = flags;
    fpu_zero = ~fpu_zero; fpu_neg = ~fpu_neg;
    setup(6'd3, 3'd7, 3'd0, 3'd6, 8'h00, 1'b0, 1'b1);
    tick();
    check("R10", "flags hold without save", 16'(flags), 16'(f_before));
    // R10: save bit with exec_en low does not capture
    setup(6'd3, 3'd7, 3'd0, 3'd6, 8'h00, 1'b1, 1'b0);
    tick();
    check("R10", "flags hold with exec_en low", 16'(flags), 16'(f_before));

    // R2: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    check("R2", "flags cleared by reset", 16'(flags), 16'h0);
    peek(3'd5, v);
    check("R2", "register cleared by reset", 16'(v), 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule